// File: doc/BRIEF.md
# Sized Logic Unit with Status Flags

This block is a purely combinational logic unit. It applies a bitwise AND, OR, XOR or NOT to two operands at an operand size of 8, 16 or 32 bits. It returns the result, zero-extended to 32 bits, together with the next value of a 32-bit status word. The second operand can come from a register or from an immediate field. A sign-extend option widens an 8-bit immediate to the operand size before the operation.

The status word enters as `flags_in` and leaves as `flags_out`. The logical operations recompute the sign, zero and parity flags from the result. They clear the overflow and carry flags and keep the auxiliary carry flag at its previous value. NOT leaves the whole status word as it was. Every bit of the status word that is not a status flag passes through unchanged. The surrounding datapath owns the register file and the storage for the status word; this block only computes the next values.

Top module: `lu_logic_flags`

## Requirements
- R1: With `op_sel` 00 the result is A AND B, with 01 it is A OR B, and with 10 it is A XOR B, each taken at operand size.
- R2: `size_sel` 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 select 32 bits. Result bits above the operand size are always zero.
- R3: With `op_sel` 11 the result is the complement of A at operand size, and `flags_out` equals `flags_in` exactly.
- R4: For AND, OR and XOR, overflow (bit 11) and carry (bit 0) of `flags_out` are 0.
- R5: For AND, OR and XOR, auxiliary carry (bit 4) of `flags_out` equals bit 4 of `flags_in`.
- R6: For AND, OR and XOR, sign (bit 7) is 1 exactly when the top bit of the result at operand size is 1.
- R7: For AND, OR and XOR, zero (bit 6) is 1 exactly when the result at operand size is zero.
- R8: For AND, OR and XOR, parity (bit 2) is 1 exactly when result bits 7:0 hold an even number of ones, whatever the operand size.
- R9: When `imm_en` and `imm_sext` are both 1, operand B is bits 7:0 of `src_b` sign-extended to the operand size. At 8-bit size this equals plain bits 7:0.
- R10: When `imm_en` is 1 and `imm_sext` is 0, operand B is `src_b` at full operand size. When `imm_en` is 0, `imm_sext` has no effect.
- R11: Bits of `flags_out` other than 0, 2, 4, 6, 7 and 11 equal the same bits of `flags_in` for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 AND, 01 OR, 10 XOR, 11 NOT |
| size_sel | input | 2 | Operand size: 00 byte, 01 16-bit, 10/11 32-bit |
| src_a | input | 32 | First operand, also the destination value |
| src_b | input | 32 | Second operand, or the immediate field |
| imm_en | input | 1 | Second operand is an immediate |
| imm_sext | input | 1 | Immediate is 8 bits, sign-extended to the operand size |
| flags_in | input | 32 | Current status word |
| result | output | 32 | Operation result, zero-extended |
| flags_out | output | 32 | Next status word |

## Verification
The hardest case to reach is a sign-extended 8-bit immediate with its top bit set at 16- or 32-bit size, where `src_b` also carries unrelated upper bits. Only the extension may fill those upper bits. A second hard case is a zero or negative result at a narrow size while the operands hold ones above the operand size. The sweep crosses every operation, every size code and every immediate mode with operand patterns that put set bits at bit 7, bit 15, bit 31 and in alternating positions. Because of that, both cases come up many times, each with a different incoming status word.

// File: rtl/lu_pkg.sv
package lu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_NOT = 2'b11
    } lu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'b00,
        SZ_WORD   = 2'b01,
        SZ_DWORD  = 2'b10,
        SZ_DWORD2 = 2'b11
    } lu_size_e;

    // status flag positions inside the status word
    localparam int FLAG_CARRY  = 0;
    localparam int FLAG_PARITY = 2;
    localparam int FLAG_AUX    = 4;
    localparam int FLAG_ZERO   = 6;
    localparam int FLAG_SIGN   = 7;
    localparam int FLAG_OVFL   = 11;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

endpackage

// File: rtl/lu_size_mask.sv
module lu_size_mask
    import lu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size_sel,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] top_bit
);

    int lane_w;

    always_comb begin
        unique case (lu_size_e'(size_sel))
            SZ_BYTE:   lane_w = BYTE_W;
            SZ_WORD:   lane_w = WORD_W;
            SZ_DWORD:  lane_w = DATA_W;
            SZ_DWORD2: lane_w = DATA_W;
            default:   lane_w = DATA_W;
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign lane_mask[i] = (i < lane_w);
        assign top_bit[i]   = (i == lane_w - 1);
    end

endmodule

// File: rtl/lu_operand_prep.sv
module lu_operand_prep #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic [DATA_W-1:0] src_b,
    input  logic              imm_en,
    input  logic              imm_sext,
    input  logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] b_eff
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] sext_val;

    assign sext_val = {{EXT_W{src_b[IMM_W-1]}}, src_b[IMM_W-1:0]};

    always_comb begin
        if (imm_en && imm_sext) begin
            b_eff = sext_val & lane_mask;
        end else begin
            b_eff = src_b & lane_mask;
        end
    end

endmodule

// File: rtl/lu_logic_core.sv
module lu_logic_core
    import lu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] res
);

    logic [DATA_W-1:0] raw;

    always_comb begin
        unique case (lu_op_e'(op_sel))
            OP_AND:  raw = a_in & b_in;
            OP_OR:   raw = a_in | b_in;
            OP_XOR:  raw = a_in ^ b_in;
            OP_NOT:  raw = ~a_in;
            default: raw = '0;
        endcase
        res = raw & lane_mask;
    end

endmodule

// File: rtl/lu_flag_gen.sv
module lu_flag_gen
    import lu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] top_bit,
    input  logic [DATA_W-1:0] flags_in,
    output logic [DATA_W-1:0] flags_out
);

    logic sign_v;
    logic zero_v;
    logic par_v;

    assign sign_v = |(res & top_bit);
    assign zero_v = (res == '0);
    assign par_v  = ~(^res[BYTE_W-1:0]);

    always_comb begin
        flags_out = flags_in;
        if (lu_op_e'(op_sel) != OP_NOT) begin
            flags_out[FLAG_CARRY]  = 1'b0;
            flags_out[FLAG_OVFL]   = 1'b0;
            flags_out[FLAG_SIGN]   = sign_v;
            flags_out[FLAG_ZERO]   = zero_v;
            flags_out[FLAG_PARITY] = par_v;
        end
    end

endmodule

// File: rtl/lu_logic_flags.sv
module lu_logic_flags #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic [1:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              imm_en,
    input  logic              imm_sext,
    input  logic [DATA_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags_out
);

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] top_bit;
    logic [DATA_W-1:0] b_eff;

    lu_size_mask #(.DATA_W(DATA_W)) u_mask (
        .size_sel  (size_sel),
        .lane_mask (lane_mask),
        .top_bit   (top_bit)
    );

    lu_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
        .src_b     (src_b),
        .imm_en    (imm_en),
        .imm_sext  (imm_sext),
        .lane_mask (lane_mask),
        .b_eff     (b_eff)
    );

    lu_logic_core #(.DATA_W(DATA_W)) u_core (
        .op_sel    (op_sel),
        .a_in      (src_a),
        .b_in      (b_eff),
        .lane_mask (lane_mask),
        .res       (result)
    );

    lu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .op_sel    (op_sel),
        .res       (result),
        .top_bit   (top_bit),
        .flags_in  (flags_in),
        .flags_out (flags_out)
    );

endmodule

// File: rtl/lu_logic_flags_chk.sv
module lu_logic_flags_chk #(
    parameter int DATA_W = 32
) (
    input logic [1:0]        op_sel,
    input logic [1:0]        size_sel,
    input logic [DATA_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] flags_out
);

    localparam logic [DATA_W-1:0] FLAG_BITS = DATA_W'(32'h0000_08D5);

    always_comb begin
        if (!$isunknown({op_sel, size_sel, flags_in, result, flags_out})) begin
            assert_not_keeps_flags_R3: assert (op_sel != 2'b11 || flags_out == flags_in)
                else $error("R3 NOT changed the status word");
            assert_ofcf_clear_R4: assert (op_sel == 2'b11 || (flags_out[0] == 1'b0 && flags_out[11] == 1'b0))
                else $error("R4 overflow or carry not cleared");
            assert_aux_hold_R5: assert (flags_out[4] == flags_in[4])
                else $error("R5 auxiliary carry changed");
            assert_upper_zero_R2: assert (size_sel[1] || (size_sel[0] ? result[DATA_W-1:16] == '0 : result[DATA_W-1:8] == '0))
                else $error("R2 bits above operand size not zero");
            assert_zero_flag_R7: assert (op_sel == 2'b11 || flags_out[6] == (result == '0))
                else $error("R7 zero flag disagrees with result");
            assert_passthru_R11: assert (((flags_out ^ flags_in) & ~FLAG_BITS) == '0)
                else $error("R11 non-flag bit changed");
        end
    end

endmodule

bind lu_logic_flags lu_logic_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .op_sel    (op_sel),
    .size_sel  (size_sel),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/tb_lu_logic_flags.sv
module tb_lu_logic_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [1:0]  size_sel = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        imm_en = 1'b0;
    logic        imm_sext = 1'b0;
    logic [31:0] flags_in = '0;
    logic [31:0] result;
    logic [31:0] flags_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lu_logic_flags dut (
        .op_sel    (op_sel),
        .size_sel  (size_sel),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm_en    (imm_en),
        .imm_sext  (imm_sext),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out)
    );

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h (op=%0d size=%0d imm=%0b%0b a=%08h b=%08h)",
                     tag, act, exp, op_sel, size_sel, imm_en, imm_sext, src_a, src_b);
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        case (k)
            0:  return 32'h0000_0000;
            1:  return 32'hFFFF_FFFF;
            2:  return 32'h8000_0000;
            3:  return 32'h0000_8000;
            4:  return 32'h0000_0080;
            5:  return 32'h0000_007F;
            6:  return 32'hAAAA_AAAA;
            7:  return 32'h5555_5555;
            8:  return 32'hFF00_FF00;
            9:  return 32'h1234_5680;
            10: return 32'hFFFF_FF00;
            11: return 32'h0001_0000;
            default: return (32'(k) * 32'h9E37_79B9) ^ (32'(k) << 7);
        endcase
    endfunction

    function automatic int width_of(input logic [1:0] s);
        if (s == 2'b00) return 8;
        if (s == 2'b01) return 16;
        return 32;
    endfunction

    task automatic run_vec(input logic [1:0] op, input logic [1:0] sz, input bit ie, input bit is,
                           input logic [31:0] a, input logic [31:0] b, input logic [31:0] f);
        int w;
        logic [31:0] msk, bx, r, ef;
        int ones;
        @(negedge clk);
        op_sel = op; size_sel = sz; imm_en = ie; imm_sext = is;
        src_a = a; src_b = b; flags_in = f;
        w = width_of(sz);
        msk = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        if (ie && is) bx = (b[7] ? (b | 32'hFFFF_FF00) : (b & 32'h0000_00FF)) & msk;
        else bx = b & msk;
        case (op)
            2'b00: r = (a & bx) & msk;
            2'b01: r = (a | bx) & msk;
            2'b10: r = (a ^ bx) & msk;
            default: r = (~a) & msk;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        #2;
        if (op == 2'b11) check(result == r, "R3 result", result, r);
        else if (ie && is) check(result == r, "R9 result", result, r);
        else if (ie || is) check(result == r, "R10 result", result, r);
        else check(result == r, "R1 result", result, r);
        check((result & ~msk) == 32'h0, "R2 upper bits", result, r);
        if (op == 2'b11) begin
            check(flags_out == f, "R3 flags", flags_out, f);
        end else begin
            ef = f;
            check(flags_out[0] == 1'b0 && flags_out[11] == 1'b0, "R4 of/cf", flags_out, ef & ~32'h801);
            check(flags_out[4] == f[4], "R5 aux", flags_out, f);
            check(flags_out[7] == r[w-1], "R6 sign", {31'h0, flags_out[7]}, {31'h0, r[w-1]});
            check(flags_out[6] == (r == 32'h0), "R7 zero", {31'h0, flags_out[6]}, {31'h0, (r == 32'h0)});
            check(flags_out[2] == (ones % 2 == 0), "R8 parity", {31'h0, flags_out[2]}, {31'h0, (ones % 2 == 0)});
        end
        check((flags_out & ~32'h0000_08D5) == (f & ~32'h0000_08D5), "R11 passthrough", flags_out, f);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: all-zero inputs give AND = 0, zero and parity set
        @(negedge clk);
        #2;
        check(result == 32'h0, "R1 reset result", result, 32'h0);
        check(flags_out == 32'h0000_0044, "R7 reset flags", flags_out, 32'h0000_0044);
        // R9 corner: 0x80 immediate sign-extended at 32 bits with junk above
        run_vec(2'b01, 2'b10, 1'b1, 1'b1, 32'h0, 32'h1234_0080, 32'h0);
        check(result == 32'hFFFF_FF80, "R9 sext dword", result, 32'hFFFF_FF80);
        // R10: sext ignored without imm_en
        run_vec(2'b01, 2'b01, 1'b0, 1'b1, 32'h0, 32'h0000_0080, 32'h0);
        check(result == 32'h0000_0080, "R10 sext ignored", result, 32'h0000_0080);
        // full sweep
        for (int op = 0; op < 4; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int im = 0; im < 4; im++)
                    for (int ka = 0; ka < 14; ka++)
                        for (int kb = 0; kb < 14; kb++)
                            run_vec(2'(op), 2'(sz), im[1], im[0], pat(ka), pat((kb + ka) % 14),
                                    pat(ka + kb + 20) ^ 32'(op * 16 + sz));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule